// File: doc/BRIEF.md
# Quadratic Nonlinear Check Generator

This block produces a 10-bit nonlinear check word over a message that arrives as a stream of 10-bit symbols. Each symbol is treated as an element of GF(2^10). The symbols are taken in pairs, first then second. The two members of each pair are multiplied in the field, and all the products are summed with XOR. The sum is then XORed with a constant mask that is set by a parameter. The result is a quadratic nonlinear function of the message. It sits beside a linear parity encoder and strengthens error detection for flash page storage.

A start pulse opens a message. The block then accepts one symbol on each cycle where the valid input is high, up to a fixed count of symbols (820 by default). Every accepted symbol is passed unchanged to the message output. When the feedback option is on, the block adds one cycle after the last symbol. In that cycle a 2:1 multiplexer puts the finished check word onto the message output. This lets a downstream parity encoder absorb the check word as message data. The done flag rises on the following cycle.

Top module: `nl_check_gen`

## Requirements
- R1: After reset, done_o is low and chk_o equals MASK. Valid symbols offered before the first start pulse have no effect on chk_o or done_o.
- R2: On the cycle after a start pulse, chk_o equals MASK and done_o is low. A start pulse in the middle of a message discards everything collected so far.
- R3: Accepted symbols are numbered from 0. An even-numbered symbol is only buffered. An odd-numbered symbol is multiplied by the buffered symbol, and the product is XORed into the accumulator. Once all N_PAIRS*2 symbols are accepted, chk_o equals the XOR of all pair products XORed with MASK.
- R4: Multiplication uses the field polynomial x^10 + x^3 + 1, with bit i of a symbol holding the coefficient of x^i. For example, 0x200 times 0x002 gives 0x009.
- R5: Any symbol multiplied by zero gives zero. A message whose every second symbol is zero ends with chk_o equal to MASK.
- R6: A cycle with sym_valid_i low is skipped. It changes neither the pairing nor the result.
- R7: When start_i and sym_valid_i are high in the same cycle, the start wins and that symbol is discarded.
- R8: While a message is being collected, every accepted symbol appears on msg_o with msg_valid_o high in the same cycle.
- R9: With FEED_EN=1, in the cycle after the last symbol is accepted, msg_valid_o is high, msg_o carries the final check word and done_o is still low. done_o rises one cycle later. With FEED_EN=0, done_o rises in the cycle right after the last symbol.
- R10: While done_o is high, symbols offered on the input are ignored. done_o and chk_o hold until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a new message and clears the accumulator |
| sym_valid_i | input | 1 | sym_i holds a symbol this cycle |
| sym_i | input | 10 | Incoming message symbol |
| msg_valid_o | output | 1 | msg_o holds a message word this cycle |
| msg_o | output | 10 | Accepted symbol, or the check word during the feedback cycle |
| done_o | output | 1 | The check word for the current message is final |
| chk_o | output | 10 | Accumulator XOR MASK |

## Verification
Two events can land on the same clock edge: a start pulse and a valid symbol. The bench provokes this by raising sym_valid_i together with start_i, with a random symbol on sym_i. The next message is then compared against a reference computed without that symbol, so any leak of the colliding symbol into the pairing shows up as a wrong check word. A second kind of overlap is a restart in the middle of a message. Its expected value is built only from the message that follows the restart.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FEED,
        ST_DONE
    } nlc_state_e;

endpackage

// File: rtl/gf_mult.sv
module gf_mult #(
    parameter int unsigned W    = 10,
    parameter logic [W-1:0] POLY = 10'h009
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);

    logic [W-1:0] prod;

    always_comb begin
        logic [W-1:0] sh;
        prod = '0;
        sh   = a_i;
        for (int i = 0; i < W; i++) begin
            if (b_i[i]) prod = prod ^ sh;
            sh = {sh[W-2:0], 1'b0} ^ (sh[W-1] ? POLY : '0);
        end
    end

    assign p_o = prod;

    // R5
    always_comb begin
        if (b_i == '0) begin
            zero_prod_chk: assert (p_o == '0);
        end
    end

endmodule

// File: rtl/nlc_ctrl.sv
module nlc_ctrl
    import nlc_pkg::*;
#(
    parameter int unsigned N_SYM   = 820,
    parameter bit          FEED_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sym_valid_i,
    output logic take_o,
    output logic feed_o,
    output logic done_o
);

    localparam int unsigned CW = $clog2(N_SYM + 1);

    typedef struct packed {
        nlc_state_e    state;
        logic [CW-1:0] count;
    } ctrl_t;

    ctrl_t q, d;
    logic  take;

    always_comb begin
        d    = q;
        take = (q.state == ST_RUN) && sym_valid_i && !start_i;
        if (start_i) begin
            d.state = ST_RUN;
            d.count = '0;
        end else begin
            case (q.state)
                ST_RUN: begin
                    if (take) begin
                        d.count = q.count + 1'b1;
                        if (q.count == CW'(N_SYM - 1))
                            d.state = FEED_EN ? ST_FEED : ST_DONE;
                    end
                end
                ST_FEED: d.state = ST_DONE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.count <= '0;
        end else begin
            q <= d;
        end
    end

    assign take_o = take;
    assign feed_o = (q.state == ST_FEED);
    assign done_o = (q.state == ST_DONE);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CW'(N_SYM));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/nlc_pair_mac.sv
module nlc_pair_mac #(
    parameter int unsigned  W    = 10,
    parameter logic [W-1:0] POLY = 10'h009
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         take_i,
    input  logic [W-1:0] sym_i,
    output logic [W-1:0] acc_o
);

    typedef struct packed {
        logic         phase;
        logic [W-1:0] held;
        logic [W-1:0] acc;
    } mac_t;

    mac_t         q, d;
    logic [W-1:0] prod;

    gf_mult #(.W(W), .POLY(POLY)) u_mul (
        .a_i (q.held),
        .b_i (sym_i),
        .p_o (prod)
    );

    always_comb begin
        d = q;
        if (clear_i) begin
            d.phase = 1'b0;
            d.acc   = '0;
        end else if (take_i) begin
            if (!q.phase) begin
                d.held  = sym_i;
                d.phase = 1'b1;
            end else begin
                d.acc   = q.acc ^ prod;
                d.phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= 1'b0;
            q.held  <= '0;
            q.acc   <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc;

    // R3
    even_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !q.phase && !clear_i) |=> $stable(q.acc));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !clear_i) |=> ($stable(q.acc) && $stable(q.phase)));

endmodule

// File: rtl/nl_check_gen.sv
module nl_check_gen #(
    parameter int unsigned N_PAIRS = 410,
    parameter logic [9:0]  MASK    = 10'h2B5,
    parameter bit          FEED_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sym_valid_i,
    input  logic [9:0] sym_i,
    output logic       msg_valid_o,
    output logic [9:0] msg_o,
    output logic       done_o,
    output logic [9:0] chk_o
);

    localparam int unsigned W     = 10;
    localparam logic [W-1:0] POLY = 10'h009;
    localparam int unsigned N_SYM = 2 * N_PAIRS;

    logic         take;
    logic         feed;
    logic [W-1:0] acc;

    nlc_ctrl #(.N_SYM(N_SYM), .FEED_EN(FEED_EN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sym_valid_i (sym_valid_i),
        .take_o      (take),
        .feed_o      (feed),
        .done_o      (done_o)
    );

    nlc_pair_mac #(.W(W), .POLY(POLY)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .take_i  (take),
        .sym_i   (sym_i),
        .acc_o   (acc)
    );

    assign chk_o       = acc ^ MASK;
    assign msg_o       = feed ? chk_o : sym_i;
    assign msg_valid_o = take | feed;

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (chk_o == MASK && !done_o));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(chk_o));

    // R9
    done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(msg_valid_o));

endmodule

// File: tb/tb_nl_check_gen.sv
module tb_nl_check_gen;

    localparam int         N    = 820;
    localparam logic [9:0] MASK = 10'h2B5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       sym_valid_i = 1'b0;
    logic [9:0] sym_i = '0;
    logic       msg_valid_o;
    logic [9:0] msg_o;
    logic       done_o;
    logic [9:0] chk_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [9:0] msg [N];

    always #10 clk = ~clk;

    nl_check_gen #(.N_PAIRS(N/2), .MASK(MASK), .FEED_EN(1'b1)) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .sym_valid_i (sym_valid_i), .sym_i (sym_i),
        .msg_valid_o (msg_valid_o), .msg_o (msg_o),
        .done_o (done_o), .chk_o (chk_o)
    );

    function automatic logic [9:0] ref_mul(input logic [9:0] a, input logic [9:0] b);
        logic [18:0] c = '0;
        for (int i = 0; i < 10; i++) if (b[i]) c = c ^ (19'(a) << i);
        for (int k = 18; k >= 10; k--) if (c[k]) c = c ^ (19'h409 << (k - 10));
        return c[9:0];
    endfunction

    function automatic logic [9:0] ref_chk();
        logic [9:0] s = '0;
        for (int i = 0; i < N; i += 2) s = s ^ ref_mul(msg[i], msg[i+1]);
        return s ^ MASK;
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_msg(input bit gaps, input bit collide);
        logic [9:0] exp = ref_chk();
        @(negedge clk);
        start_i = 1'b1; sym_valid_i = collide; sym_i = 10'($urandom);
        @(negedge clk);
        start_i = 1'b0; sym_valid_i = 1'b0;
        check("R2 chk after start", chk_o, MASK);
        check("R2 done after start", 10'(done_o), 10'd0);
        for (int i = 0; i < N; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                sym_valid_i = 1'b0; sym_i = 10'($urandom);
                @(negedge clk);
            end
            sym_valid_i = 1'b1; sym_i = msg[i];
            if (i == 3) begin
                #1;
                check("R8 pass valid", 10'(msg_valid_o), 10'd1);
                check("R8 pass data", msg_o, msg[i]);
            end
            @(negedge clk);
        end
        sym_valid_i = 1'b0;
        #1;
        check("R9 feed valid", 10'(msg_valid_o), 10'd1);
        check("R9 feed word", msg_o, exp);
        check("R9 done low in feed", 10'(done_o), 10'd0);
        @(negedge clk);
        check("R9 done rises", 10'(done_o), 10'd1);
        check(collide ? "R7 collide result" : (gaps ? "R6 gap result" : "R3 result"), chk_o, exp);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset chk", chk_o, MASK);
        check("R1 reset done", 10'(done_o), 10'd0);
        sym_valid_i = 1'b1;
        repeat (4) begin sym_i = 10'($urandom); @(negedge clk); end
        sym_valid_i = 1'b0;
        check("R1 pre-start ignore", chk_o, MASK);

        for (int k = 0; k < 2; k++) begin
            foreach (msg[i]) msg[i] = 10'($urandom);
            run_msg(1'b0, 1'b0);
        end

        foreach (msg[i]) msg[i] = '0;
        run_msg(1'b0, 1'b0);

        foreach (msg[i]) msg[i] = (i % 2 == 0) ? 10'($urandom) : 10'h000;
        run_msg(1'b0, 1'b0);
        check("R5 zero product", chk_o, MASK);

        foreach (msg[i]) msg[i] = '0;
        msg[100] = 10'h200; msg[101] = 10'h002;
        run_msg(1'b0, 1'b0);
        check("R4 reduction", chk_o, 10'h009 ^ MASK);

        foreach (msg[i]) msg[i] = 10'($urandom);
        run_msg(1'b1, 1'b0);

        foreach (msg[i]) msg[i] = 10'($urandom);
        run_msg(1'b0, 1'b1);

        sym_valid_i = 1'b1;
        repeat (10) begin sym_i = 10'($urandom); @(negedge clk); end
        sym_valid_i = 1'b0;
        check("R10 chk held", chk_o, ref_chk());
        check("R10 done held", 10'(done_o), 10'd1);

        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; sym_valid_i = 1'b1;
        repeat (301) begin sym_i = 10'($urandom); @(negedge clk); end
        sym_valid_i = 1'b0;
        foreach (msg[i]) msg[i] = 10'($urandom);
        run_msg(1'b0, 1'b0);
        check("R2 restart discards", chk_o, ref_chk());

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule